// File: doc/BRIEF.md
# Pixel to bus-cycle packer

This block takes pixels from a valid/ready stream and cuts each one into words for a parallel display port. Pixels may be 12, 16, 18 or 24 bits wide. The port may be 8, 9, 12 or 16 lines wide. The packing rule depends on how the pixel width relates to the port width. A pixel can fill one, two or three bus words exactly. When twice the pixel width equals three times the port width, two pixels share three words, and one word then holds the tail of the first pixel and the head of the second. Words leave on a valid/ready stream, most significant part first, and each word is right-aligned on the port lines.

A frame begins when a start pulse arrives while the block is idle. The start pulse latches the pixel width code, the line width code and the frame length in pixels. The block then takes exactly that many pixels and flushes every word. It signals the end of the frame with a one-cycle done pulse and returns to idle. A pixel/line pairing that fits no packing rule raises an error flag and produces no traffic.

Top module: `pixel_bus_packer`

## Requirements
- R1: The start pulse latches the packing code on `cycle_fmt`, and `cycle_fmt` holds it for the whole frame. The code is 0 when the pixel width equals the line width, 1 when it is twice the line width, 2 when it is three times the line width, and 3 when twice the pixel width equals three times the line width. The pixel width codes on `cfg_dtype` are 0=12, 1=16, 2=18, 3=24 bits. The line codes on `cfg_lines` are 0=8, 1=9, 2=12, 3=16 lines.
- R2: In codes 0, 1 and 2, each pixel is sent most significant slice first, in slices as wide as the line count. Each slice sits in the low bits of `out_word` with the bits above it zero. For example, 16-bit 0x1234 on 8 lines gives 0x12 then 0x34, and 24-bit 0xA1B2C3 on 8 lines gives 0xA1, 0xB2, 0xC3. Bits of `in_pixel` above the pixel width are ignored.
- R3: In code 3, pixels A then B form three words. The first word is the top part of A. The second word is the remaining low part of A followed by the top part of B. The third word is the rest of B. For example, on 16 lines, 0x112233 and 0x445566 give 0x1122, 0x3344, 0x5566.
- R4: In code 3, when the frame has an odd pixel count, the last pixel ends with one word that holds its low part in the upper bits and zeros below. For example, 0xABCDEF on 16 lines ends with 0xEF00.
- R5: A start with a pairing that fits no rule sets `cfg_err`. The block then stays idle: `busy`, `in_ready` and `out_valid` stay low. The next start with a valid pairing clears `cfg_err`.
- R6: A pixel is taken only when all words of the previous pixel have been handed off. `in_ready` is never high while `out_valid` is high, and every accepted pixel is followed by `out_valid` on the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold.
- R8: Exactly `frame_len` pixels are accepted per frame. `frame_done` pulses for one cycle once every word has been handed off, and `busy` falls at the same edge.
- R9: A start while `busy` is high is ignored. Changes to `cfg_dtype`, `cfg_lines` and `frame_len` during a frame have no effect on that frame.
- R10: A start with a valid pairing and `frame_len` of zero pulses `frame_done` at the next edge, leaves `busy` low and emits no word.
- R11: After reset, `busy`, `frame_done`, `cfg_err`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dtype | input | 2 | Pixel width code, latched at start |
| cfg_lines | input | 2 | Port line-count code, latched at start |
| frame_len | input | CNT_W | Pixels in the frame, latched at start |
| start | input | 1 | Begins a frame when idle |
| in_valid | input | 1 | Pixel stream valid |
| in_ready | output | 1 | Pixel stream ready |
| in_pixel | input | PIX_MAX | Pixel, right-aligned |
| out_valid | output | 1 | Bus word valid |
| out_ready | input | 1 | Bus word accepted |
| out_word | output | BUS_MAX | Bus word, right-aligned on the lines |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Last start had an unusable pairing |
| cycle_fmt | output | 2 | Latched packing code |

## Verification
A wrong fill count in the bit accumulator does not stay hidden. The very next word after the slip comes out misaligned, so the error shows at the ports within one word, and the frame then ends with the wrong word total. A pixel counter that is off by one shows up as the wrong number of `in_ready` handshakes, and it either brings `frame_done` in early or never lets it arrive. A packing code latched at the wrong time shows on `cycle_fmt` in the first cycle of the frame.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;

  localparam int CODE_W = 2;
  localparam int WID_W  = 5;

  typedef enum logic [CODE_W-1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_SPLIT = 2'd3
  } cyc_fmt_e;

  function automatic logic [WID_W-1:0] pix_width(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd16;
      2'd2:    return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [WID_W-1:0] line_width(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pxpk_fmt_decode.sv
module pxpk_fmt_decode
  import pxpk_pkg::*;
(
  input  logic [CODE_W-1:0] dtype_code,
  input  logic [CODE_W-1:0] lines_code,
  output logic [WID_W-1:0]  pix_bits,
  output logic [WID_W-1:0]  bus_bits,
  output cyc_fmt_e          fmt,
  output logic              legal
);

  logic [WID_W+1:0] p_ext;
  logic [WID_W+1:0] b_ext;

  always_comb begin
    pix_bits = pix_width(dtype_code);
    bus_bits = line_width(lines_code);
    p_ext    = {2'b00, pix_bits};
    b_ext    = {2'b00, bus_bits};
    legal    = 1'b1;
    fmt      = FMT_ONE;
    if (p_ext == b_ext) begin
      fmt = FMT_ONE;
    end else if (p_ext == (b_ext << 1)) begin
      fmt = FMT_TWO;
    end else if (p_ext == (b_ext + (b_ext << 1))) begin
      fmt = FMT_THREE;
    end else if ((p_ext << 1) == (b_ext + (b_ext << 1))) begin
      fmt = FMT_SPLIT;
    end else begin
      legal = 1'b0;
    end
  end

endmodule

// File: rtl/pxpk_frame_ctrl.sv
module pxpk_frame_ctrl #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len_in,
  input  logic             legal,
  input  logic             pix_take,
  input  logic             drained,
  output logic             launch,
  output logic             pix_pending,
  output logic             busy,
  output logic             frame_done,
  output logic             cfg_err
);

  logic [CNT_W-1:0] remaining_q, remaining_d;
  logic             busy_d, done_d, err_d;
  logic             idle_start, zero_go, bad_go, done_now;

  always_comb begin
    idle_start  = start && !busy;
    launch      = idle_start && legal && (len_in != '0);
    zero_go     = idle_start && legal && (len_in == '0);
    bad_go      = idle_start && !legal;
    pix_pending = (remaining_q != '0);
    done_now    = busy && !pix_pending && drained;

    busy_d = busy;
    if (launch)        busy_d = 1'b1;
    else if (done_now) busy_d = 1'b0;

    remaining_d = remaining_q;
    if (launch)        remaining_d = len_in;
    else if (pix_take) remaining_d = remaining_q - CNT_W'(1);

    done_d = done_now || zero_go;

    err_d = cfg_err;
    if (bad_go)                   err_d = 1'b1;
    else if (idle_start && legal) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining_q <= '0;
      busy        <= 1'b0;
      frame_done  <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      if (launch || pix_take) remaining_q <= remaining_d;
      busy       <= busy_d;
      frame_done <= done_d;
      cfg_err    <= err_d;
    end
  end

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pix_take) |=> (remaining_q == $past(remaining_q)));

  // R8
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> frame_done);

  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

endmodule

// File: rtl/pxpk_word_packer.sv
module pxpk_word_packer
  import pxpk_pkg::*;
#(
  parameter int PIX_MAX = 24,
  parameter int BUS_MAX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               busy,
  input  logic               more_pix,
  input  logic [WID_W-1:0]   pix_bits,
  input  logic [WID_W-1:0]   bus_bits,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_MAX-1:0] in_pixel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BUS_MAX-1:0] out_word,
  output logic               pix_take,
  output logic               drained
);

  localparam int ACC_W  = PIX_MAX + BUS_MAX;
  localparam int FILL_W = $clog2(ACC_W + 1);
  localparam logic [FILL_W-1:0] ACC_F = FILL_W'(ACC_W);
  localparam logic [FILL_W-1:0] BUS_F = FILL_W'(BUS_MAX);

  logic [ACC_W-1:0]   acc_q, acc_d, pix_aligned;
  logic [FILL_W-1:0]  fill_q, fill_d, pix_f, bus_f;
  logic [BUS_MAX-1:0] top_slice;
  logic               have_word, tail_word, pop, acc_en;

  always_comb begin
    pix_f       = FILL_W'(pix_bits);
    bus_f       = FILL_W'(bus_bits);
    have_word   = (fill_q >= bus_f);
    tail_word   = !more_pix && (fill_q != '0);
    out_valid   = busy && (have_word || tail_word);
    in_ready    = busy && more_pix && !out_valid;
    pix_take    = in_valid && in_ready;
    pop         = out_valid && out_ready;
    drained     = (fill_q == '0);
    top_slice   = acc_q[ACC_W-1 -: BUS_MAX];
    out_word    = top_slice >> (BUS_F - bus_f);
    pix_aligned = ACC_W'(in_pixel) << (ACC_F - pix_f);
    acc_en      = clear || pop || pix_take;

    acc_d  = acc_q;
    fill_d = fill_q;
    if (clear) begin
      acc_d  = '0;
      fill_d = '0;
    end else if (pop) begin
      acc_d  = acc_q << bus_f;
      fill_d = have_word ? (fill_q - bus_f) : '0;
    end else if (pix_take) begin
      acc_d  = acc_q | (pix_aligned >> fill_q);
      fill_d = fill_q + pix_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R6
  word_after_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
  import pxpk_pkg::*;
#(
  parameter int PIX_MAX = 24,
  parameter int BUS_MAX = 16,
  parameter int CNT_W   = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_dtype,
  input  logic [1:0]         cfg_lines,
  input  logic [CNT_W-1:0]   frame_len,
  input  logic               start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_MAX-1:0] in_pixel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BUS_MAX-1:0] out_word,
  output logic               busy,
  output logic               frame_done,
  output logic               cfg_err,
  output logic [1:0]         cycle_fmt
);

  logic [WID_W-1:0] dec_pix, dec_bus, pix_q, bus_q;
  cyc_fmt_e         dec_fmt, fmt_q;
  logic             dec_legal, launch, pix_pending, pix_take, drained;

  pxpk_fmt_decode u_dec (
    .dtype_code (cfg_dtype),
    .lines_code (cfg_lines),
    .pix_bits   (dec_pix),
    .bus_bits   (dec_bus),
    .fmt        (dec_fmt),
    .legal      (dec_legal)
  );

  pxpk_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_in      (frame_len),
    .legal       (dec_legal),
    .pix_take    (pix_take),
    .drained     (drained),
    .launch      (launch),
    .pix_pending (pix_pending),
    .busy        (busy),
    .frame_done  (frame_done),
    .cfg_err     (cfg_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      bus_q <= '0;
      fmt_q <= FMT_ONE;
    end else if (launch) begin
      pix_q <= dec_pix;
      bus_q <= dec_bus;
      fmt_q <= dec_fmt;
    end
  end

  assign cycle_fmt = fmt_q;

  pxpk_word_packer #(.PIX_MAX(PIX_MAX), .BUS_MAX(BUS_MAX)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .busy      (busy),
    .more_pix  (pix_pending),
    .pix_bits  (pix_q),
    .bus_bits  (bus_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pixel  (in_pixel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .pix_take  (pix_take),
    .drained   (drained)
  );

  // R1
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cycle_fmt));

endmodule

// File: tb/pixel_bus_packer_test.sv
module pixel_bus_packer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 22;
  localparam int NVEC = 13;

  // entry: {dtype[15:14], lines[13:12], fmt[11:10], err[9], stall[8:7], npix[6:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd1, 2'd3, 2'd0, 1'b0, 2'd0, 7'd5},
    {2'd0, 2'd2, 2'd0, 1'b0, 2'd1, 7'd4},
    {2'd1, 2'd0, 2'd1, 1'b0, 2'd0, 7'd6},
    {2'd2, 2'd1, 2'd1, 1'b0, 2'd2, 7'd3},
    {2'd3, 2'd2, 2'd1, 1'b0, 2'd0, 7'd4},
    {2'd3, 2'd0, 2'd2, 1'b0, 2'd1, 7'd4},
    {2'd3, 2'd3, 2'd3, 1'b0, 2'd0, 7'd6},
    {2'd3, 2'd3, 2'd3, 1'b0, 2'd2, 7'd5},
    {2'd0, 2'd0, 2'd3, 1'b0, 2'd1, 7'd4},
    {2'd2, 2'd2, 2'd3, 1'b0, 2'd0, 7'd3},
    {2'd0, 2'd3, 2'd0, 1'b1, 2'd0, 7'd4},
    {2'd1, 2'd2, 2'd0, 1'b1, 2'd0, 7'd4},
    {2'd2, 2'd3, 2'd0, 1'b1, 2'd0, 7'd4}
  };

  logic             clk, rst_n;
  logic [1:0]       cfg_dtype, cfg_lines;
  logic [CNT_W-1:0] frame_len;
  logic             start, in_valid, in_ready, out_valid, out_ready;
  logic [23:0]      in_pixel;
  logic [15:0]      out_word;
  logic             busy, frame_done, cfg_err;
  logic [1:0]       cycle_fmt;

  int n_run, n_fail, cycles;
  logic [23:0] pix_mem [128];
  logic [15:0] cap [256];
  int cap_n;

  pixel_bus_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_dtype(cfg_dtype), .cfg_lines(cfg_lines),
    .frame_len(frame_len), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .busy(busy), .frame_done(frame_done), .cfg_err(cfg_err),
    .cycle_fmt(cycle_fmt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int pw(input logic [1:0] c);
    case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction

  function automatic int bw(input logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction

  // bit stream view: all pixels MSB first, cut into slices of b lines
  function automatic logic [15:0] exp_word(input int k, input int n, input int p, input int b);
    logic [15:0] w;
    w = '0;
    for (int j = 0; j < b; j++) begin
      int s;
      s = k * b + j;
      if (s < n * p) w[b-1-j] = pix_mem[s / p][p - 1 - (s % p)];
    end
    return w;
  endfunction

  task automatic run_frame(input logic [1:0] dt, input logic [1:0] ln, input int n,
                           input int stall, input bit poke, input logic [1:0] efmt,
                           input bit eerr, input string req);
    int p, b, want, taken, cyc;
    bit done_seen, stalled, overlap;
    logic [15:0] held;
    p = pw(dt); b = bw(ln);
    want = eerr ? 0 : (n * p + b - 1) / b;
    taken = 0; cap_n = 0; done_seen = 0; stalled = 0; overlap = 0; held = '0;
    @(negedge clk);
    cfg_dtype = dt; cfg_lines = ln; frame_len = CNT_W'(n); start = 1'b1;
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(cfg_err == eerr, "R5", "error flag after start", cfg_err, eerr);
    if (!eerr) check(cycle_fmt == efmt, "R1", "packing code", cycle_fmt, efmt);
    else check(busy == 1'b0, "R5", "busy after bad start", busy, 0);
    for (cyc = 0; cyc < 3000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      case (stall)
        1:       out_ready = (cyc % 3) != 0;
        2:       out_ready = (cyc % 4) < 2;
        default: out_ready = 1'b1;
      endcase
      in_valid = (stall == 2) ? ((cyc % 2) == 0) : 1'b1;
      in_pixel = pix_mem[taken[6:0]] | (24'hFFFFFF << p);
      if (poke && cyc == 2) begin
        start = 1'b1; frame_len = CNT_W'(50); cfg_dtype = 2'd3; cfg_lines = 2'd0;
      end else begin
        start = 1'b0;
      end
      #1;
      if (stalled) check(out_valid && out_word == held, "R7", "word held under stall", out_word, held);
      if (in_ready && out_valid) overlap = 1;
      if (out_valid && out_ready) begin
        if (cap_n < 256) cap[cap_n] = out_word;
        check(out_word == exp_word(cap_n, n, p, b), req, "word value", out_word, exp_word(cap_n, n, p, b));
        cap_n++;
      end
      stalled = out_valid && !out_ready;
      held = out_word;
      if (in_valid && in_ready) taken++;
      if (frame_done) begin
        done_seen = 1;
        break;
      end
      if (eerr && cyc == 12) break;
    end
    check(!overlap, "R6", "in_ready together with out_valid", overlap, 0);
    check(cap_n == want, req, "word count", cap_n, want);
    check(taken == (eerr ? 0 : n), "R8", "pixels accepted", taken, eerr ? 0 : n);
    check(done_seen == !eerr, "R8", "frame_done seen", done_seen, !eerr);
    if (done_seen) check(busy == 1'b0, "R8", "busy with frame_done", busy, 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(frame_done == 1'b0, "R8", "frame_done width", frame_done, 0);
    check(busy == 1'b0 && out_valid == 1'b0, "R8", "idle after frame", {busy, out_valid}, 0);
    if (poke) check(cycle_fmt == efmt, "R9", "code kept after ignored start", cycle_fmt, efmt);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cycles = 0;
    cfg_dtype = '0; cfg_lines = '0; frame_len = '0; start = 0;
    in_valid = 0; in_pixel = '0; out_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(busy == 0 && frame_done == 0 && cfg_err == 0, "R11", "status at reset",
          {busy, frame_done, cfg_err}, 0);
    check(in_ready == 0 && out_valid == 0, "R11", "handshakes at reset", {in_ready, out_valid}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      string tag;
      e = VEC[v];
      for (int i = 0; i < 128; i++)
        pix_mem[i] = (24'(i * 40503 + v * 7919) ^ 24'h5A3C96) & ((24'd1 << pw(e[15:14])) - 24'd1);
      if (e[11:10] != 2'd3) tag = "R2";
      else if (e[0]) tag = "R4";
      else tag = "R3";
      run_frame(e[15:14], e[13:12], int'(e[6:0]), int'(e[8:7]), 1'b0, e[11:10], e[9], tag);
    end

    // R2 directed: 16-bit on 8 lines, high byte first
    pix_mem[0] = 24'h001234;
    run_frame(2'd1, 2'd0, 1, 1, 1'b0, 2'd1, 1'b0, "R2");
    check(cap[0] == 16'h0012 && cap[1] == 16'h0034, "R2", "16b on 8 lines", {cap[0], cap[1]}, 32'h00120034);

    // R2 directed: 24-bit on 8 lines
    pix_mem[0] = 24'hA1B2C3;
    run_frame(2'd3, 2'd0, 1, 0, 1'b0, 2'd2, 1'b0, "R2");
    check(cap[0] == 16'h00A1 && cap[1] == 16'h00B2 && cap[2] == 16'h00C3, "R2", "24b on 8 lines",
          {cap[0], cap[1], cap[2]}, 48'h00A100B200C3);

    // R3 directed: two pixels straddle three words
    pix_mem[0] = 24'h112233; pix_mem[1] = 24'h445566;
    run_frame(2'd3, 2'd3, 2, 2, 1'b0, 2'd3, 1'b0, "R3");
    check(cap[0] == 16'h1122 && cap[1] == 16'h3344 && cap[2] == 16'h5566, "R3", "split layout",
          {cap[0], cap[1], cap[2]}, 48'h112233445566);

    // R4 directed: lone final pixel is padded
    pix_mem[0] = 24'hABCDEF;
    run_frame(2'd3, 2'd3, 1, 0, 1'b0, 2'd3, 1'b0, "R4");
    check(cap[0] == 16'hABCD && cap[1] == 16'hEF00, "R4", "padded tail", {cap[0], cap[1]}, 32'hABCDEF00);

    // R9 start during a frame is ignored
    for (int i = 0; i < 128; i++) pix_mem[i] = 24'(i * 3001 + 17) & 24'hFFFF;
    run_frame(2'd1, 2'd3, 4, 1, 1'b1, 2'd0, 1'b0, "R9");

    // R10 zero-length frame
    @(negedge clk);
    cfg_dtype = 2'd1; cfg_lines = 2'd3; frame_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(frame_done == 1'b1 && busy == 1'b0, "R10", "zero length done", {frame_done, busy}, 2'b10);
    @(negedge clk);
    #1;
    check(frame_done == 1'b0 && out_valid == 1'b0, "R10", "zero length quiet", {frame_done, out_valid}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule